// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block produces the SCL and SDA line timing for the master side of an I2C bus. It is driven one bus event at a time. The event is a data bit, a START, a repeated START or a STOP. For each event it drives the open-drain enables of both lines, holds SCL low while it waits, and pulses a done strobe when the event is over. Byte sequencing, addressing and arbitration stay in the controller above it. That controller issues one event, waits for the strobe, and then issues the next.

All timing comes from a single programmable timing word. A prescale field divides the kernel clock into a time quantum. Four counts, each a multiple of that quantum, set the SCL low time, the SCL high time, the data hold delay after SCL falls and the data setup delay before SCL rises. The low and high counts are reused for the START, repeated-START and STOP spacing. When SCL is let go, the high-time count does not start until the line is seen high, so a slave can stretch the clock.

The line outputs are active-high "pull low" enables. The sampled line levels come back on `sclIn` and `sdaIn` and must already be synchronous to `clk`.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, and while `enable` is low, both line enables are 0 (lines released), `doneStb` is 0 and `cmdReady` is 0. With `enable` high and no event in progress, `cmdReady` is 1.
- R2: The timing word `cfgWord` has these fields: bits [7:0] low count L, [15:8] high count H, [19:16] hold count D, [23:20] setup count S and [27:24] prescale P. One quantum Q is (P+1) clock cycles, and every interval below is a whole number of quanta.
- R3: A data bit (`cmdOp`=0, `cmdBit` is the level, 1 meaning released) starts with SCL driven low. SDA changes D·Q cycles after the accepting edge. SCL is then released (L+1+S+1)·Q cycles after that SDA change, so both the hold delay and the setup delay lengthen the low phase.
- R4: The high phase lasts (H+1)·Q cycles and is counted from the first edge at which SCL is sampled high. It ends with a one-cycle `doneStb`, SCL driven low in the same cycle, and `rxBit` equal to SDA as sampled at that edge.
- R5: While SCL is released but held low from outside, no high-phase time is counted and no `doneStb` is produced. The done edge moves later by exactly the length of the stretch.
- R6: START (`cmdOp`=1, issued with both lines released) waits (L+1)·Q cycles with both lines released. It then drives SDA low with SCL still released, holds that for (H+1)·Q cycles, and ends with SCL driven low and `doneStb`.
- R7: Repeated START (`cmdOp`=2, issued with SCL low) releases SDA after the hold delay and releases SCL after the low and setup delays, as in R3. Once SCL is seen high it waits (L+1)·Q cycles, drives SDA low, waits (H+1)·Q cycles, and ends with SCL driven low and `doneStb`.
- R8: STOP (`cmdOp`=3, issued with SCL low) drives SDA low after the hold delay and releases SCL as in R3. Once SCL is seen high it waits (H+1)·Q cycles, then releases SDA and pulses `doneStb`, leaving both lines released.
- R9: A `cfgWe` write is taken only while `enable` is low. A write while enabled leaves all timings unchanged.
- R10: With D=0, the SDA change of a bit, repeated START or STOP happens at the edge that accepts the event.
- R11: Dropping `enable` during an event aborts it. At the next edge both lines are released, and no `doneStb` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low aborts and opens the timing word for writing |
| cfgWe | input | 1 | Timing word write strobe |
| cfgWord | input | 28 | Timing word (fields in R2) |
| cmdValid | input | 1 | Event request |
| cmdOp | input | 2 | Event code: 0 bit, 1 START, 2 repeated START, 3 STOP |
| cmdBit | input | 1 | Bit level for a data bit; 1 releases SDA so it can be read |
| cmdReady | output | 1 | Idle and enabled; an event is accepted when valid and ready are both high |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Drive SCL low when 1 |
| sdaOe | output | 1 | Drive SDA low when 1 |
| doneStb | output | 1 | One-cycle end-of-event strobe |
| rxBit | output | 1 | SDA sampled at the end of the last bit's high phase |

## Verification
The assertions take for granted that `sclIn` and `sdaIn` follow the line enables as an open-drain bus would. An external party may hold SCL low only while it is released and waiting to rise, and it never pulls SCL low during a counted high phase. The assertions also assume that events come in protocol order: START only on an idle bus, and bits, repeated START and STOP only after a START. The bench models both lines as wired-AND of the block and a slave model. It stretches SCL only in the wait-for-high window and pulls SDA only to return read data. Its random sequences are always framed as START, bits, an optional repeated START with more bits, and a closing STOP.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    OP_BIT    = 2'd0,
    OP_START  = 2'd1,
    OP_RSTART = 2'd2,
    OP_STOP   = 2'd3
  } busOp_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOW,
    ST_SETUP,
    ST_WAITHI,
    ST_HIGH,
    ST_BUF,
    ST_SUSTA,
    ST_HDSTA,
    ST_SUSTO
  } phase_e;

  // One-hot load strobes from control to the interval timer.
  typedef struct packed {
    logic ldLow;
    logic ldHigh;
    logic ldHold;
    logic ldSetup;
  } timerCmd_t;

endpackage

// File: rtl/i2c_bt_timer.sv
module i2c_bt_timer
  import i2c_bt_pkg::*;
#(
  parameter int PRESC_W  = 4,
  parameter int PERIOD_W = 8,
  parameter int DELAY_W  = 4,
  parameter int CFG_W    = PRESC_W + 2 * PERIOD_W + 2 * DELAY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  timerCmd_t        tcmd,
  output logic             expired,
  output logic             holdZero
);

  localparam int CNT_W    = PERIOD_W + 1;
  localparam int HIGH_LSB = PERIOD_W;
  localparam int HOLD_LSB = 2 * PERIOD_W;
  localparam int SET_LSB  = HOLD_LSB + DELAY_W;
  localparam int PRE_LSB  = SET_LSB + DELAY_W;

  logic [CFG_W-1:0]    cfgReg;
  logic [PERIOD_W-1:0] lowF, highF;
  logic [DELAY_W-1:0]  holdF, setupF;
  logic [PRESC_W-1:0]  prescF;

  logic [CNT_W-1:0]    loadVal;
  logic [CNT_W-1:0]    qLeft;
  logic [PRESC_W-1:0]  preLeft;
  logic                anyLoad;

  // Timing word: writable only while the block is disabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cfgReg <= '0;
    else if (cfgWe && !enable) cfgReg <= cfgWord;
  end

  assign lowF   = cfgReg[HIGH_LSB-1:0];
  assign highF  = cfgReg[HOLD_LSB-1:HIGH_LSB];
  assign holdF  = cfgReg[SET_LSB-1:HOLD_LSB];
  assign setupF = cfgReg[PRE_LSB-1:SET_LSB];
  assign prescF = cfgReg[CFG_W-1:PRE_LSB];

  assign holdZero = (holdF == '0);
  assign anyLoad  = tcmd.ldLow | tcmd.ldHigh | tcmd.ldHold | tcmd.ldSetup;

  // Interval length in quanta for the requested phase.
  always_comb begin
    loadVal = '0;
    if (tcmd.ldLow)   loadVal = CNT_W'(lowF) + CNT_W'(1);
    if (tcmd.ldHigh)  loadVal = CNT_W'(highF) + CNT_W'(1);
    if (tcmd.ldHold)  loadVal = CNT_W'(holdF);
    if (tcmd.ldSetup) loadVal = CNT_W'(setupF) + CNT_W'(1);
  end

  // Prescaler restarts with every load so each interval is exact.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qLeft   <= '0;
      preLeft <= '0;
    end else if (anyLoad) begin
      qLeft   <= loadVal;
      preLeft <= prescF;
    end else if (qLeft != '0) begin
      if (preLeft == '0) begin
        preLeft <= prescF;
        qLeft   <= qLeft - CNT_W'(1);
      end else begin
        preLeft <= preLeft - PRESC_W'(1);
      end
    end
  end

  // Flags the last cycle of the interval, so the next phase starts on time.
  assign expired = (qLeft == '0) || ((qLeft == CNT_W'(1)) && (preLeft == '0));

endmodule

// File: rtl/i2c_bt_ctrl.sv
module i2c_bt_ctrl
  import i2c_bt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       expired,
  input  logic       holdZero,
  output timerCmd_t  tcmd,
  output logic       cmdReady,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       doneStb,
  output logic       rxBit
);

  phase_e state, nState;
  busOp_e curOp, nOp, reqOp;
  logic   curBit, nBit;
  logic   nScl, nSda, nDone, nRx;

  function automatic logic sdaDriveFor(busOp_e op, logic b);
    logic drv;
    case (op)
      OP_BIT:  drv = ~b;
      OP_STOP: drv = 1'b1;
      default: drv = 1'b0;
    endcase
    return drv;
  endfunction

  assign reqOp    = busOp_e'(cmdOp);
  assign cmdReady = enable && (state == ST_IDLE);

  always_comb begin
    nState = state;
    nOp    = curOp;
    nBit   = curBit;
    nScl   = sclOe;
    nSda   = sdaOe;
    nDone  = 1'b0;
    nRx    = rxBit;
    tcmd   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdReady && cmdValid) begin
          nOp  = reqOp;
          nBit = cmdBit;
          if (reqOp == OP_START) begin
            nState     = ST_BUF;
            tcmd.ldLow = 1'b1;
          end else if (holdZero) begin
            nState     = ST_LOW;
            tcmd.ldLow = 1'b1;
            nSda       = sdaDriveFor(reqOp, cmdBit);
          end else begin
            nState      = ST_HOLD;
            tcmd.ldHold = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (expired) begin
          nState     = ST_LOW;
          tcmd.ldLow = 1'b1;
          nSda       = sdaDriveFor(curOp, curBit);
        end
      end
      ST_LOW: begin
        if (expired) begin
          nState       = ST_SETUP;
          tcmd.ldSetup = 1'b1;
        end
      end
      ST_SETUP: begin
        if (expired) begin
          nState = ST_WAITHI;
          nScl   = 1'b0;
        end
      end
      ST_WAITHI: begin
        if (sclIn) begin
          case (curOp)
            OP_RSTART: begin
              nState     = ST_SUSTA;
              tcmd.ldLow = 1'b1;
            end
            OP_STOP: begin
              nState      = ST_SUSTO;
              tcmd.ldHigh = 1'b1;
            end
            default: begin
              nState      = ST_HIGH;
              tcmd.ldHigh = 1'b1;
            end
          endcase
        end
      end
      ST_HIGH: begin
        if (expired) begin
          nState = ST_IDLE;
          nScl   = 1'b1;
          nDone  = 1'b1;
          nRx    = sdaIn;
        end
      end
      ST_BUF, ST_SUSTA: begin
        if (expired) begin
          nState      = ST_HDSTA;
          tcmd.ldHigh = 1'b1;
          nSda        = 1'b1;
        end
      end
      ST_HDSTA: begin
        if (expired) begin
          nState = ST_IDLE;
          nScl   = 1'b1;
          nDone  = 1'b1;
        end
      end
      ST_SUSTO: begin
        if (expired) begin
          nState = ST_IDLE;
          nSda   = 1'b0;
          nDone  = 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curOp   <= OP_BIT;
      curBit  <= 1'b1;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      doneStb <= 1'b0;
      rxBit   <= 1'b0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      doneStb <= 1'b0;
    end else begin
      state   <= nState;
      curOp   <= nOp;
      curBit  <= nBit;
      sclOe   <= nScl;
      sdaOe   <= nSda;
      doneStb <= nDone;
      rxBit   <= nRx;
    end
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int  PRESC_W  = 4,
  parameter int  PERIOD_W = 8,
  parameter int  DELAY_W  = 4,
  localparam int CFG_W    = PRESC_W + 2 * PERIOD_W + 2 * DELAY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             cmdBit,
  output logic             cmdReady,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             doneStb,
  output logic             rxBit
);

  timerCmd_t tcmd;
  logic      expired;
  logic      holdZero;

  i2c_bt_timer #(
    .PRESC_W (PRESC_W),
    .PERIOD_W(PERIOD_W),
    .DELAY_W (DELAY_W),
    .CFG_W   (CFG_W)
  ) timer_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cfgWe   (cfgWe),
    .cfgWord (cfgWord),
    .tcmd    (tcmd),
    .expired (expired),
    .holdZero(holdZero)
  );

  i2c_bt_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdBit  (cmdBit),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .expired (expired),
    .holdZero(holdZero),
    .tcmd    (tcmd),
    .cmdReady(cmdReady),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe),
    .doneStb (doneStb),
    .rxBit   (rxBit)
  );

endmodule

// File: rtl/i2c_bt_checker.sv
module i2c_bt_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cmdValid,
  input logic cmdReady,
  input logic sclIn,
  input logic sclOe,
  input logic sdaOe,
  input logic doneStb
);

  // R11: disabling releases both lines and suppresses the strobe
  a_r11_disable_releases: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclOe && !sdaOe && !doneStb));

  // R4: the done strobe lasts a single cycle
  a_r4_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  // R4: SCL is only pulled low again at the end of an event
  a_r4_scl_fall_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> doneStb);

  // R3: an accepted event takes the block out of the ready state
  a_r3_accept_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R5: no end of event while SCL is released but held low from outside
  a_r5_no_done_while_stretched: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!sclOe) && $past(!sclIn) && $past(enable)) |-> !doneStb);

  // R6: SDA falls with SCL high only as a start edge, SCL stays released
  a_r6_start_edge_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && $past(!sclOe)) |-> !sclOe);

  // R8: SDA rises with SCL high only as the closing edge of STOP
  a_r8_stop_edge_ends_op: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !sclOe && $past(!sclOe) && $past(enable) && enable) |-> doneStb);

endmodule

bind i2c_bit_timer i2c_bt_checker chk_i (.*);

// File: tb/i2c_bit_timer_tb_top.sv
module i2c_bit_timer_tb_top;
  import i2c_bt_pkg::*;

  localparam int CFG_W = 28;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             cfgWe = 1'b0;
  logic [CFG_W-1:0] cfgWord = '0;
  logic             cmdValid = 1'b0;
  logic [1:0]       cmdOp = 2'd0;
  logic             cmdBit = 1'b0;
  logic             cmdReady;
  logic             sclIn, sdaIn, sclOe, sdaOe, doneStb, rxBit;
  logic             stretchHold = 1'b0;
  logic             slaveLow = 1'b0;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int mP = 0, mL = 0, mH = 0, mD = 0, mS = 0;
  int seedDummy;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Open-drain bus model: wired-AND of block and slave.
  assign sclIn = !sclOe && !stretchHold;
  assign sdaIn = !sdaOe && !slaveLow;

  i2c_bit_timer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBit(cmdBit), .cmdReady(cmdReady),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe),
    .doneStb(doneStb), .rxBit(rxBit)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(negedge clk) begin
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL R2 watchdog cycles=%0d limit=%0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int quant();
    return mP + 1;
  endfunction

  // Write the timing word; the model follows R9.
  task automatic writeCfg(input int p, input int l, input int h, input int d, input int s);
    @(negedge clk);
    cfgWord = {p[3:0], s[3:0], d[3:0], h[7:0], l[7:0]};
    cfgWe   = 1'b1;
    if (!enable) begin
      mP = p; mL = l; mH = h; mD = d; mS = s;
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setCfg(input int p, input int l, input int h, input int d, input int s);
    @(negedge clk);
    enable = 1'b0;
    writeCfg(p, l, h, d, s);
    enable = 1'b1;
  endtask

  // Issue one event and record when the lines move.
  task automatic runCmd(input busOp_e op, input logic b, input int k, input logic slv,
                        output int aEdge, output int rel, output int sdaFirst,
                        output int sdaLast, output int doneCyc, output int rxv);
    logic pScl, pSda;
    int   t;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdBit   = b;
    slaveLow = slv;
    stretchHold = (k > 0);
    pScl = sclOe;
    pSda = sdaOe;
    aEdge = cyc + 1;
    rel = -1; sdaFirst = -1; sdaLast = -1; doneCyc = -1; rxv = -1;
    @(negedge clk);
    cmdValid = 1'b0;
    t = 0;
    while (t < 20000) begin
      if (sdaOe != pSda) begin
        if (sdaFirst < 0) sdaFirst = cyc;
        sdaLast = cyc;
      end
      if (!sclOe && pScl) rel = cyc;
      if (rel >= 0 && stretchHold && cyc == rel + k) stretchHold = 1'b0;
      if (doneStb) begin
        doneCyc = cyc;
        rxv = rxBit;
        break;
      end
      pScl = sclOe;
      pSda = sdaOe;
      @(negedge clk);
      t++;
    end
    stretchHold = 1'b0;
  endtask

  task automatic doBit(input logic b, input int k, input logic slv);
    int a, rel, f, l, dn, rx, q, expRel, expDone;
    logic prevSda;
    q = quant();
    @(negedge clk);
    prevSda = sdaOe;
    runCmd(OP_BIT, b, k, slv, a, rel, f, l, dn, rx);
    expRel  = a + (mD + mL + 1 + mS + 1) * q;
    expDone = expRel + 1 + k + (mH + 1) * q;
    if (prevSda != !b) begin
      if (mD == 0) chk("R10 bit sda at accept", f, a);
      else         chk("R3 bit sda after hold", f, a + mD * q);
    end
    chk("R3 bit scl release", rel, expRel);
    if (k > 0) chk("R5 stretched bit done", dn, expDone);
    else       chk("R4 bit done (R2 quantum)", dn, expDone);
    chk("R4 rx bit", rx, b ? int'(!slv) : 0);
    chk("R4 scl low at done", int'(sclOe), 1);
    chk("R3 sda level after bit", int'(sdaOe), int'(!b));
  endtask

  task automatic doStart();
    int a, rel, f, l, dn, rx, q;
    q = quant();
    runCmd(OP_START, 1'b0, 0, 1'b0, a, rel, f, l, dn, rx);
    chk("R6 start sda fall", f, a + (mL + 1) * q);
    chk("R6 start done (R2 quantum)", dn, a + (mL + 1 + mH + 1) * q);
    chk("R6 start scl low", int'(sclOe), 1);
    chk("R6 start sda low", int'(sdaOe), 1);
  endtask

  task automatic doRstart(input int k);
    int a, rel, f, l, dn, rx, q, expRel, expLow;
    logic prevSda;
    q = quant();
    @(negedge clk);
    prevSda = sdaOe;
    runCmd(OP_RSTART, 1'b0, k, 1'b0, a, rel, f, l, dn, rx);
    expRel = a + (mD + mL + 1 + mS + 1) * q;
    expLow = expRel + 1 + k + (mL + 1) * q;
    if (prevSda) chk("R7 rstart sda release", f, a + mD * q);
    chk("R7 rstart scl release", rel, expRel);
    chk("R7 rstart sda fall", l, expLow);
    chk("R7 rstart done", dn, expLow + (mH + 1) * q);
    chk("R7 rstart lines", int'({sclOe, sdaOe}), 3);
  endtask

  task automatic doStop(input int k);
    int a, rel, f, l, dn, rx, q, expRel, expDone;
    logic prevSda;
    q = quant();
    @(negedge clk);
    prevSda = sdaOe;
    runCmd(OP_STOP, 1'b0, k, 1'b0, a, rel, f, l, dn, rx);
    expRel  = a + (mD + mL + 1 + mS + 1) * q;
    expDone = expRel + 1 + k + (mH + 1) * q;
    if (!prevSda) begin
      if (mD == 0) chk("R10 stop sda at accept", f, a);
      else         chk("R8 stop sda low after hold", f, a + mD * q);
    end
    chk("R8 stop scl release", rel, expRel);
    chk("R8 stop done", dn, expDone);
    chk("R8 stop sda release at done", l, expDone);
    chk("R8 stop lines released", int'({sclOe, sdaOe}), 0);
  endtask

  initial begin
    seedDummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    chk("R1 reset lines", int'({sclOe, sdaOe}), 0);
    chk("R1 reset done", int'(doneStb), 0);
    chk("R1 reset not ready", int'(cmdReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 disabled not ready", int'(cmdReady), 0);

    // Smallest timing: every field zero, D=0 path.
    writeCfg(0, 0, 0, 0, 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R1 enabled ready", int'(cmdReady), 1);
    doStart();
    doBit(1'b0, 0, 1'b0);
    doBit(1'b1, 0, 1'b1);
    doBit(1'b1, 0, 1'b0);
    doStop(0);

    // Mid timing with clock stretching on each kind of event.
    setCfg(2, 5, 4, 3, 2);
    doStart();
    doBit(1'b1, 7, 1'b0);
    doBit(1'b0, 1, 1'b0);
    doRstart(3);
    doBit(1'b0, 0, 1'b0);
    doStop(2);

    // R9: write while enabled is ignored; timing stays at 2,5,4,3,2.
    writeCfg(9, 200, 100, 9, 9);
    doStart();
    doBit(1'b0, 0, 1'b0);
    doStop(0);

    // Largest timing word.
    setCfg(15, 255, 255, 15, 15);
    doStart();
    doBit(1'b1, 0, 1'b1);
    doStop(0);

    // R11: abort in the middle of a bit.
    setCfg(1, 6, 6, 2, 2);
    doStart();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = OP_BIT; cmdBit = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 abort lines released", int'({sclOe, sdaOe}), 0);
    chk("R11 abort not ready", int'(cmdReady), 0);
    enable = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (doneStb) seen = 1;
      end
      chk("R11 no done after abort", seen, 0);
    end
    chk("R11 idle ready again", int'(cmdReady), 1);

    // Random framed transfers.
    for (int n = 0; n < 6; n++) begin
      setCfg($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15),
             $urandom_range(0, 4), $urandom_range(0, 4));
      doStart();
      for (int i = 0; i < int'($urandom_range(3, 6)); i++)
        doBit(1'($urandom_range(0, 1)), $urandom_range(0, 1) * $urandom_range(1, 3),
              1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 1) begin
        doRstart($urandom_range(0, 2));
        for (int i = 0; i < 2; i++)
          doBit(1'($urandom_range(0, 1)), 0, 1'($urandom_range(0, 1)));
      end
      doStop($urandom_range(0, 2));
    end

    summary();
    $finish;
  end

endmodule